// File: doc/BRIEF.md
# Stack Pointer, Data Pointer and Status Word Register Unit

This unit holds three architectural registers of an 8-bit accumulator-based core: the stack pointer, the 16-bit data pointer (a high byte and a low byte) and the program status word. It carries out four commands: push, pop, a 16-bit immediate load of the data pointer, and a direct write to one of its special registers. It also drives a synchronous single-port interface to the core's internal 256-byte data RAM. Read data from that RAM returns one cycle after the request.

Every command runs through the same fixed sequence. The first cycle is the RAM access and the second is the register update. The cycle after the update raises a one-cycle done pulse, and in that cycle the new register values are already visible. The unit also handles two architectural corner cases. A pop whose destination is the stack pointer loads the popped byte into the stack pointer and skips the decrement. The parity bit of the status word is maintained by hardware from the accumulator, and software writes to it have no effect.

Top module: `sreg_unit`

## Requirements
- R1: After reset, sp_o is 0x07, dptr_o is 0x0000, psw_o is 0x00 (with acc_i at 0) and done_o is low.
- R2: A command is taken when cmd_valid_i is high at a clock edge while the unit is idle. The RAM request is active in the following cycle. The registers update at the second edge after acceptance, and done_o is high for exactly the one cycle after that edge. Any cmd_valid_i seen before that done cycle is ignored.
- R3: Push (cmd_op_i = 0) writes cmd_data_i to RAM[sp+1] with ram_we_o high, and sp_o becomes sp+1.
- R4: Pop (cmd_op_i = 1) reads RAM[sp] and presents the byte on pop_data_o. When the destination cmd_addr_i is not the stack pointer, sp_o becomes sp-1.
- R5: A pop whose destination is the stack pointer address 0x81 leaves the popped byte in sp_o with no decrement. For example, sp 0x0A with RAM[0x0A] = 0x08 gives sp 0x08.
- R6: A pop whose destination is 0x82 (data pointer low), 0x83 (data pointer high) or 0xD0 (status word) loads the popped byte into that register.
- R7: The immediate load (cmd_op_i = 2) puts cmd_imm_i[15:8] into the high byte and cmd_imm_i[7:0] into the low byte of dptr_o. For example, 0xD85B gives 0xD8 and 0x5B.
- R8: A register write (cmd_op_i = 3) to 0x81, 0x82, 0x83 or 0xD0 loads cmd_data_i into that register. A write to any other address changes none of sp_o, dptr_o or psw_o.
- R9: psw_o[0] equals the XOR of all bits of acc_i as sampled at the previous clock edge, so it is 1 for an odd count of ones. A write to the status word, whether by register write or by pop, leaves bit 0 unchanged and updates bits 7..1.
- R10: The stack pointer wraps modulo 256. A push at sp 0xFF writes RAM[0x00] and gives sp 0x00. A pop at sp 0x00 reads RAM[0x00] and gives sp 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 push, 1 pop, 2 data pointer load, 3 register write |
| cmd_addr_i | input | 8 | Pop destination or register write address |
| cmd_data_i | input | 8 | Push data or register write data |
| cmd_imm_i | input | 16 | Immediate for the data pointer load |
| acc_i | input | 8 | Accumulator value used for parity |
| ram_req_o | output | 1 | RAM access request |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the request |
| pop_data_o | output | 8 | Last popped byte |
| done_o | output | 1 | Command completion pulse |
| sp_o | output | 8 | Stack pointer |
| dptr_o | output | 16 | Data pointer, high byte on top |
| psw_o | output | 8 | Program status word, bit 0 is parity |

## Verification
Two things can land on the same register in the same update cycle. A pop into the stack pointer carries both the popped byte and the decrement every pop applies, and a write to the status word carries both the software value and the hardware parity for bit 0. The bench sets up the stack pointer at 0x0A with 0x08 stored there and pops into the stack pointer. Any result other than 0x08 exposes a decrement that won the conflict. It then writes status word values whose bit 0 disagrees with the accumulator's parity, and checks that bit 0 follows the accumulator while bits 7..1 take the written value.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_LDDP = 2'd2,
    OP_WR   = 2'd3
  } op_e;

  localparam logic [7:0] ADR_SP  = 8'h81;
  localparam logic [7:0] ADR_DPL = 8'h82;
  localparam logic [7:0] ADR_DPH = 8'h83;
  localparam logic [7:0] ADR_PSW = 8'hD0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_UPD  = 2'd2
  } state_e;
endpackage

// File: rtl/sreg_seq.sv
module sreg_seq
  import sreg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  output logic take_o,
  output logic acc_phase_o,
  output logic upd_o,
  output logic done_o
);
  state_e state_q, state_d;

  assign take_o      = cmd_valid_i && (state_q == ST_IDLE);
  assign acc_phase_o = (state_q == ST_ACC);
  assign upd_o       = (state_q == ST_UPD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) state_d = ST_ACC;
      ST_ACC:  state_d = ST_UPD;
      ST_UPD:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q == ST_UPD);
    end
  end

  // R2
  acc_follows_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> acc_phase_o);
  // R2
  done_after_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> (done_o && !upd_o && !acc_phase_o));
endmodule

// File: rtl/sreg_sp.sv
module sreg_sp
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  op_e               op_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] pop_data_i,
  output logic [DATA_W-1:0] sp_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  logic [DATA_W-1:0] sp_q, sp_d;

  always_comb begin
    sp_d = sp_q;
    if (upd_i) begin
      unique case (op_i)
        OP_PUSH: sp_d = sp_q + ONE;
        OP_POP:  sp_d = (addr_i == ADR_SP) ? pop_data_i : sp_q - ONE;
        OP_WR:   if (addr_i == ADR_SP) sp_d = wr_data_i;
        default: sp_d = sp_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= SP_RST;
    else         sp_q <= sp_d;
  end

  assign sp_o = sp_q;

  // R3
  push_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_PUSH) |=> sp_q == $past(sp_q) + ONE);
  // R4
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_POP && addr_i != ADR_SP) |=> sp_q == $past(sp_q) - ONE);
  // R5
  pop_into_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_POP && addr_i == ADR_SP) |=> sp_q == $past(pop_data_i));
endmodule

// File: rtl/sreg_dptr.sv
module sreg_dptr
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  op_e               op_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] pop_data_i,
  input  logic [PTR_W-1:0]  imm_i,
  output logic [PTR_W-1:0]  dptr_o
);
  logic [DATA_W-1:0] hi_q, lo_q, hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (upd_i) begin
      unique case (op_i)
        OP_LDDP: begin
          hi_d = imm_i[PTR_W-1:DATA_W];
          lo_d = imm_i[DATA_W-1:0];
        end
        OP_POP: begin
          if (addr_i == ADR_DPH) hi_d = pop_data_i;
          if (addr_i == ADR_DPL) lo_d = pop_data_i;
        end
        OP_WR: begin
          if (addr_i == ADR_DPH) hi_d = wr_data_i;
          if (addr_i == ADR_DPL) lo_d = wr_data_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign dptr_o = {hi_q, lo_q};

  // R7
  ld_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_LDDP) |=> dptr_o == $past(imm_i));
endmodule

// File: rtl/sreg_psw.sv
module sreg_psw
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  op_e               op_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:1] wr_flags_i,
  input  logic [DATA_W-1:1] pop_flags_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] psw_o
);
  logic [DATA_W-1:1] flags_q, flags_d;
  logic              par_q;

  always_comb begin
    flags_d = flags_q;
    if (upd_i && addr_i == ADR_PSW) begin
      if (op_i == OP_WR)  flags_d = wr_flags_i;
      if (op_i == OP_POP) flags_d = pop_flags_i;
    end
  end

  // parity is hardware-owned; bit 0 has no software write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      par_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      par_q   <= ^acc_i;
    end
  end

  assign psw_o = {flags_q, par_q};

  // R9
  par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(acc_i) |=> $stable(psw_o[0]));
  // R9
  flags_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_WR && addr_i == ADR_PSW) |=> psw_o[DATA_W-1:1] == $past(wr_flags_i));
endmodule

// File: rtl/sreg_unit.sv
module sreg_unit
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [7:0]        cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic [PTR_W-1:0]  cmd_imm_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [PTR_W-1:0]  dptr_o,
  output logic [DATA_W-1:0] psw_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              take, acc_phase, upd;
  op_e               op_q;
  logic [7:0]        addr_q;
  logic [DATA_W-1:0] data_q;
  logic [PTR_W-1:0]  imm_q;
  logic [DATA_W-1:0] pop_q;

  sreg_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .take_o      (take),
    .acc_phase_o (acc_phase),
    .upd_o       (upd),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_PUSH;
      addr_q <= '0;
      data_q <= '0;
      imm_q  <= '0;
    end else if (take) begin
      op_q   <= op_e'(cmd_op_i);
      addr_q <= cmd_addr_i;
      data_q <= cmd_data_i;
      imm_q  <= cmd_imm_i;
    end
  end

  assign ram_req_o   = acc_phase && (op_q == OP_PUSH || op_q == OP_POP);
  assign ram_we_o    = acc_phase && (op_q == OP_PUSH);
  assign ram_addr_o  = (op_q == OP_PUSH) ? sp_o + ONE : sp_o;
  assign ram_wdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pop_q <= '0;
    else if (upd && op_q == OP_POP) pop_q <= ram_rdata_i;
  end
  assign pop_data_o = pop_q;

  sreg_sp #(.DATA_W(DATA_W)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .op_i       (op_q),
    .addr_i     (addr_q),
    .wr_data_i  (data_q),
    .pop_data_i (ram_rdata_i),
    .sp_o       (sp_o)
  );

  sreg_dptr #(.DATA_W(DATA_W)) u_dptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .op_i       (op_q),
    .addr_i     (addr_q),
    .wr_data_i  (data_q),
    .pop_data_i (ram_rdata_i),
    .imm_i      (imm_q),
    .dptr_o     (dptr_o)
  );

  sreg_psw #(.DATA_W(DATA_W)) u_psw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (upd),
    .op_i        (op_q),
    .addr_i      (addr_q),
    .wr_flags_i  (data_q[DATA_W-1:1]),
    .pop_flags_i (ram_rdata_i[DATA_W-1:1]),
    .acc_i       (acc_i),
    .psw_o       (psw_o)
  );

  // R3
  we_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_req_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  wr_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_q == OP_WR && addr_q != ADR_SP && addr_q != ADR_DPL &&
     addr_q != ADR_DPH && addr_q != ADR_PSW) |=> ($stable(sp_o) && $stable(dptr_o)));
endmodule

// File: tb/sreg_unit_tb.sv
module sreg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_addr = 8'h00;
  logic [7:0]  cmd_data = 8'h00;
  logic [15:0] cmd_imm = 16'h0000;
  logic [7:0]  acc = 8'h00;
  logic        ram_req, ram_we;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata, pop_data, sp, psw;
  logic        done;
  logic [15:0] dptr;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [256];
  logic       s_req, s_we;
  logic [7:0] s_addr, s_wdata;

  always #4 clk = ~clk;

  sreg_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_imm_i(cmd_imm), .acc_i(acc),
    .ram_req_o(ram_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .pop_data_o(pop_data),
    .done_o(done), .sp_o(sp), .dptr_o(dptr), .psw_o(psw)
  );

  always_ff @(posedge clk) begin
    if (ram_req && ram_we)  mem[ram_addr] <= ram_wdata;
    if (ram_req && !ram_we) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one command through its full sequence; RAM port sampled in the access cycle
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] adr,
                         input logic [7:0] dat, input logic [15:0] imm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = adr; cmd_data = dat; cmd_imm = imm;
    @(negedge clk);
    cmd_valid = 1'b0;
    s_req = ram_req; s_we = ram_we; s_addr = ram_addr; s_wdata = ram_wdata;
    @(negedge clk);
    chk("R2 no done in update cycle", done, 1'b0);
    @(negedge clk);
    chk("R2 done pulse", done, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 sp", sp, 8'h07);
    chk("R1 dptr", dptr, 16'h0000);
    chk("R1 psw", psw, 8'h00);
    chk("R1 done", done, 1'b0);
  endtask

  task automatic t_push_pop;
    run_cmd(2'd0, 8'h00, 8'h5A, 16'h0);
    chk("R3 req", {s_req, s_we}, 2'b11);
    chk("R3 addr", s_addr, 8'h08);
    chk("R3 wdata", s_wdata, 8'h5A);
    chk("R3 sp", sp, 8'h08);
    run_cmd(2'd0, 8'h00, 8'hC3, 16'h0);
    chk("R3 addr2", s_addr, 8'h09);
    chk("R3 sp2", sp, 8'h09);
    run_cmd(2'd1, 8'hE0, 8'h00, 16'h0);
    chk("R4 read req", {s_req, s_we}, 2'b10);
    chk("R4 read addr", s_addr, 8'h09);
    chk("R4 pop data", pop_data, 8'hC3);
    chk("R4 sp", sp, 8'h08);
  endtask

  task automatic t_pop_sp;
    run_cmd(2'd3, 8'h81, 8'h09, 16'h0);
    chk("R8 sp write", sp, 8'h09);
    run_cmd(2'd0, 8'h00, 8'h08, 16'h0);
    chk("R5 setup sp", sp, 8'h0A);
    run_cmd(2'd1, 8'h81, 8'h00, 16'h0);
    chk("R5 pop into sp", sp, 8'h08);
    chk("R5 pop data", pop_data, 8'h08);
  endtask

  task automatic t_dptr;
    run_cmd(2'd2, 8'h00, 8'h00, 16'hD85B);
    chk("R7 load", dptr, 16'hD85B);
    chk("R7 no ram", s_req, 1'b0);
    // sp 0x08 holds 0x5A
    run_cmd(2'd1, 8'h83, 8'h00, 16'h0);
    chk("R6 pop dph", dptr, 16'h5A5B);
    chk("R6 sp", sp, 8'h07);
    run_cmd(2'd3, 8'h82, 8'h11, 16'h0);
    chk("R8 dpl write", dptr, 16'h5A11);
    run_cmd(2'd3, 8'h90, 8'hFF, 16'h0);
    chk("R8 other sp", sp, 8'h07);
    chk("R8 other dptr", dptr, 16'h5A11);
    chk("R8 other psw", psw, 8'h00);
  endtask

  task automatic t_wrap;
    run_cmd(2'd3, 8'h81, 8'hFF, 16'h0);
    run_cmd(2'd0, 8'h00, 8'h77, 16'h0);
    chk("R10 push addr", s_addr, 8'h00);
    chk("R10 push sp", sp, 8'h00);
    run_cmd(2'd1, 8'hE0, 8'h00, 16'h0);
    chk("R10 pop addr", s_addr, 8'h00);
    chk("R10 pop data", pop_data, 8'h77);
    chk("R10 pop sp", sp, 8'hFF);
  endtask

  task automatic t_busy;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 8'h44;
    @(negedge clk);
    cmd_op = 2'd2; cmd_imm = 16'hBEEF;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 busy done", done, 1'b1);
    chk("R2 busy sp", sp, 8'h00);
    chk("R2 busy dptr", dptr, 16'h5A11);
    @(negedge clk);
    @(negedge clk);
    chk("R2 busy later done", done, 1'b0);
    chk("R2 busy later dptr", dptr, 16'h5A11);
  endtask

  task automatic t_parity;
    @(negedge clk); acc = 8'h07;
    @(negedge clk);
    chk("R9 odd parity", psw, 8'h01);
    run_cmd(2'd3, 8'hD0, 8'h00, 16'h0);
    chk("R9 write clears flags keeps P", psw, 8'h01);
    acc = 8'h03;
    run_cmd(2'd3, 8'hD0, 8'hFE, 16'h0);
    chk("R9 write flags even", psw, 8'hFE);
    acc = 8'h00;
    run_cmd(2'd3, 8'hD0, 8'h81, 16'h0);
    chk("R9 write bit0 ignored", psw, 8'h80);
    // sp 0x00 holds 0x44 from the busy test: pop into psw
    run_cmd(2'd1, 8'hD0, 8'h00, 16'h0);
    chk("R6 pop psw", psw, 8'h44);
    acc = 8'h01;
    run_cmd(2'd0, 8'h00, 8'h00, 16'h0);
    run_cmd(2'd1, 8'hD0, 8'h00, 16'h0);
    chk("R9 pop bit0 ignored", psw, 8'h01);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    ram_rdata = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_push_pop();
    t_pop_sp();
    t_dptr();
    t_wrap();
    t_busy();
    t_parity();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule